// File: doc/BRIEF.md
# Watchdog Timer with Sleep Wake

This block is a watchdog that counts on its own always-on, low-rate clock. That clock keeps running when the main system clock is stopped, for example during sleep. Firmware must restart the count before a programmed period runs out. If it does not, the block asks for a reset of the device while the device is running. If the device is asleep, the same expiry only asks for a wake-up, so execution resumes instead of restarting.

The base period is a fixed number of watchdog-clock ticks, set by a parameter. An optional prescaler can be placed in front of the base counter and stretches the period by a power of two, up to 128. Firmware restarts the count with a clear strobe. Entering sleep restarts it as well. A status flag drops on every expiry and is raised again at power-up and by either restart strobe, so firmware can tell after the fact that a timeout happened.

All inputs are taken to be synchronous to the watchdog clock. The restart strobes are one watchdog-clock cycle wide.

Top module: `wdtSleepWake`

## Requirements
- R1: While `rstN` is low, and after it is released, `resetReq` and `wakeReq` are 0, `toFlag` is 1, and both counters start from zero.
- R2: With `preAssign` = 0 the ratio is 1. An expiry then happens on the `BASE_TICKS`-th enabled clock edge after the counters were last zeroed.
- R3: With `preAssign` = 1, the 3-bit field `preRatio` value k selects ratio 2^k (0 gives 1, 7 gives 128). The expiry happens `BASE_TICKS`·2^k edges after the counters were last zeroed.
- R4: A `swClear` pulse zeroes the base counter and the prescaler, so the next expiry comes a full period after that edge. It also sets `toFlag` to 1.
- R5: An expiry while `sleeping` = 0 drives `resetReq` high for exactly one cycle, starting on the clock edge that completes the period.
- R6: An expiry while `sleeping` = 1 drives `wakeReq` high for exactly one cycle and never drives `resetReq`.
- R7: A `sleepEnter` pulse zeroes both counters like `swClear` and sets `toFlag` to 1.
- R8: While `cfgEnable` = 0, no request is issued and the counters hold their value. They resume from that value when the bit returns to 1.
- R9: `toFlag` goes to 0 on the same edge that raises either request.
- R10: After an expiry both counters restart from zero, so an ignored watchdog expires again every period.
- R11: A restart strobe on the edge that would otherwise complete the period wins: no request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wdtClk | input | 1 | Always-on watchdog clock |
| rstN | input | 1 | Active-low asynchronous power-up reset |
| cfgEnable | input | 1 | Static enable configuration bit |
| swClear | input | 1 | Software restart strobe |
| sleepEnter | input | 1 | Strobe on entry into sleep |
| sleeping | input | 1 | High while the device is in sleep |
| preAssign | input | 1 | 1 places the prescaler in front of the watchdog |
| preRatio | input | 3 | Prescaler ratio select, ratio = 2^value |
| resetReq | output | 1 | One-cycle device reset request |
| wakeReq | output | 1 | One-cycle wake-up request |
| toFlag | output | 1 | Timeout status, 0 after an expiry |

## Verification
A request is due on exactly the edge that is period = `BASE_TICKS`·ratio edges after the edge that zeroed the counters. That is the reset release, the last expiry or the sampled strobe. The request registers on that same edge, and `toFlag` falls with it. A restart strobe shows `toFlag` = 1 one edge after it is sampled. The driver converts each restart into the cycle numbers of every request expected in the window it then waits out, and queues them with the expected kind. The monitor samples on the falling clock edge and compares each due entry with the outputs in that cycle. It flags any request that arrives when nothing is due.

// File: rtl/wdt_pkg.sv
package wdtPkg;

  // Strobes from control to the counting datapath
  typedef struct packed {
    logic baseClr;   // zero the base counter
    logic baseStep;  // advance the base counter by one
    logic preClr;    // zero the prescaler
    logic preStep;   // advance or wrap the prescaler
  } wdtStrobes_t;

endpackage

// File: rtl/wdt_datapath.sv
module wdtDatapath
  import wdtPkg::*;
#(
  parameter int BASE_TICKS = 16,
  parameter int RATIO_BITS = 3
) (
  input  logic                  wdtClk,
  input  logic                  rstN,
  input  wdtStrobes_t           strobes,
  input  logic [RATIO_BITS-1:0] ratioSel,
  output logic                  preWrap,
  output logic                  baseLast
);

  localparam int PRE_W  = (1 << RATIO_BITS) - 1;
  localparam int BASE_W = (BASE_TICKS > 2) ? $clog2(BASE_TICKS) : 1;

  logic [PRE_W-1:0]  preCnt;
  logic [PRE_W-1:0]  preMask;
  logic [BASE_W-1:0] baseCnt;

  // Mask of ratio-1: low ratioSel bits set
  always_comb begin
    preMask = '0;
    for (int i = 0; i < PRE_W; i++) begin
      preMask[i] = (i < int'(ratioSel));
    end
  end

  assign preWrap  = (preCnt >= preMask);
  assign baseLast = (baseCnt == BASE_W'(BASE_TICKS - 1));

  always_ff @(posedge wdtClk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (strobes.preClr) begin
      preCnt <= '0;
    end else if (strobes.preStep) begin
      preCnt <= preWrap ? '0 : preCnt + 1'b1;
    end
  end

  always_ff @(posedge wdtClk or negedge rstN) begin
    if (!rstN) begin
      baseCnt <= '0;
    end else if (strobes.baseClr) begin
      baseCnt <= '0;
    end else if (strobes.baseStep) begin
      baseCnt <= baseCnt + 1'b1;
    end
  end

  // Base counter stays inside one period
  assert_base_bounded_R2: assert property (@(posedge wdtClk) disable iff (!rstN)
    baseCnt < BASE_W'(BASE_TICKS) || BASE_TICKS == (1 << BASE_W));

  // A clear strobe leaves the counters at zero
  assert_clear_zero_R4: assert property (@(posedge wdtClk) disable iff (!rstN)
    strobes.baseClr |=> (baseCnt == '0));

  assert_pre_clear_zero_R4: assert property (@(posedge wdtClk) disable iff (!rstN)
    strobes.preClr |=> (preCnt == '0));

endmodule

// File: rtl/wdt_ctrl.sv
module wdtCtrl
  import wdtPkg::*;
(
  input  logic        wdtClk,
  input  logic        rstN,
  input  logic        cfgEnable,
  input  logic        swClear,
  input  logic        sleepEnter,
  input  logic        sleeping,
  input  logic        preAssign,
  input  logic        preWrap,
  input  logic        baseLast,
  output wdtStrobes_t strobes,
  output logic        resetReq,
  output logic        wakeReq,
  output logic        toFlag
);

  logic tickNow;
  logic userClr;
  logic advance;
  logic expire;

  assign tickNow = preAssign ? preWrap : 1'b1;
  assign userClr = swClear | sleepEnter;
  assign advance = cfgEnable & tickNow & ~userClr;
  assign expire  = advance & baseLast;

  always_comb begin
    strobes.baseClr  = userClr | expire;
    strobes.baseStep = advance;
    strobes.preClr   = userClr | expire | ~preAssign;
    strobes.preStep  = cfgEnable & preAssign & ~userClr;
  end

  always_ff @(posedge wdtClk or negedge rstN) begin
    if (!rstN) begin
      resetReq <= 1'b0;
      wakeReq  <= 1'b0;
      toFlag   <= 1'b1;
    end else begin
      resetReq <= expire & ~sleeping;
      wakeReq  <= expire & sleeping;
      if (expire) begin
        toFlag <= 1'b0;
      end else if (userClr) begin
        toFlag <= 1'b1;
      end
    end
  end

  assert_pulse_exclusive_R6: assert property (@(posedge wdtClk) disable iff (!rstN)
    !(resetReq && wakeReq));

  assert_wake_when_asleep_R6: assert property (@(posedge wdtClk) disable iff (!rstN)
    wakeReq |-> $past(sleeping));

  assert_reset_when_awake_R5: assert property (@(posedge wdtClk) disable iff (!rstN)
    resetReq |-> !$past(sleeping));

  assert_single_reset_pulse_R5: assert property (@(posedge wdtClk) disable iff (!rstN)
    resetReq |=> !resetReq);

  assert_disabled_silent_R8: assert property (@(posedge wdtClk) disable iff (!rstN)
    !$past(cfgEnable) |-> !(resetReq || wakeReq));

  assert_flag_drops_with_pulse_R9: assert property (@(posedge wdtClk) disable iff (!rstN)
    $fell(toFlag) |-> (resetReq || wakeReq));

endmodule

// File: rtl/wdt_sleep_wake.sv
module wdtSleepWake
  import wdtPkg::*;
#(
  parameter int BASE_TICKS = 16,
  parameter int RATIO_BITS = 3
) (
  input  logic                  wdtClk,
  input  logic                  rstN,
  input  logic                  cfgEnable,
  input  logic                  swClear,
  input  logic                  sleepEnter,
  input  logic                  sleeping,
  input  logic                  preAssign,
  input  logic [RATIO_BITS-1:0] preRatio,
  output logic                  resetReq,
  output logic                  wakeReq,
  output logic                  toFlag
);

  wdtStrobes_t strobes;
  logic        preWrap;
  logic        baseLast;

  wdtCtrl uCtrl (
    .wdtClk    (wdtClk),
    .rstN      (rstN),
    .cfgEnable (cfgEnable),
    .swClear   (swClear),
    .sleepEnter(sleepEnter),
    .sleeping  (sleeping),
    .preAssign (preAssign),
    .preWrap   (preWrap),
    .baseLast  (baseLast),
    .strobes   (strobes),
    .resetReq  (resetReq),
    .wakeReq   (wakeReq),
    .toFlag    (toFlag)
  );

  wdtDatapath #(
    .BASE_TICKS(BASE_TICKS),
    .RATIO_BITS(RATIO_BITS)
  ) uDatapath (
    .wdtClk  (wdtClk),
    .rstN    (rstN),
    .strobes (strobes),
    .ratioSel(preRatio),
    .preWrap (preWrap),
    .baseLast(baseLast)
  );

endmodule

// File: tb/wdt_sleep_wake_test.sv
`timescale 1ns/1ps
module wdtSleepWake_test;

  localparam int BASE = 16;

  logic       clk = 1'b0;
  logic       rstN, cfgEnable, swClear, sleepEnter, sleeping, preAssign;
  logic [2:0] preRatio;
  logic       resetReq, wakeReq, toFlag;

  always #4 clk = ~clk;

  wdtSleepWake #(.BASE_TICKS(BASE), .RATIO_BITS(3)) uut (
    .wdtClk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .swClear(swClear),
    .sleepEnter(sleepEnter), .sleeping(sleeping), .preAssign(preAssign),
    .preRatio(preRatio), .resetReq(resetReq), .wakeReq(wakeReq), .toFlag(toFlag)
  );

  typedef struct {
    int    due;
    bit    wake;
    string tag;
  } expItem_t;

  expItem_t q[$];
  expItem_t item;
  int       cyc = 0;
  int       total = 0;
  int       bad = 0;
  int       nextDue;
  int       period;
  string    curTag = "R2";
  bit       finished = 0;

  always @(posedge clk) begin
    if (!rstN) cyc <= 0;
    else       cyc <= cyc + 1;
  end

  task automatic check(bit ok, string tag, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // Monitor: compare due entries with the outputs
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (q.size() > 0 && q[0].due == cyc) begin
        item = q.pop_front();
        check(resetReq == !item.wake && wakeReq == item.wake, item.tag,
              "request kind {reset,wake}", int'({resetReq, wakeReq}), item.wake ? 1 : 2);
        check(toFlag == 1'b0, "R9", "toFlag with request", int'(toFlag), 0);
      end else if (resetReq || wakeReq) begin
        check(1'b0, curTag, "unexpected request at cycle", cyc, -1);
      end
    end
  end

  // Queue every request due inside the next n cycles, then wait
  task automatic runFor(int n);
    int endC = cyc + n;
    while (nextDue <= endC) begin
      q.push_back('{nextDue, bit'(sleeping), curTag});
      nextDue += period;
    end
    repeat (n) @(negedge clk);
  endtask

  task automatic restart(string tag, bit assign_, int sel, bit viaSleep, bit sleepLvl);
    curTag    = tag;
    preAssign = assign_;
    preRatio  = 3'(sel);
    sleeping  = sleepLvl;
    if (viaSleep) sleepEnter = 1'b1;
    else          swClear    = 1'b1;
    period  = assign_ ? (BASE << sel) : BASE;
    nextDue = cyc + 1 + period;
    @(negedge clk);
    swClear    = 1'b0;
    sleepEnter = 1'b0;
    check(toFlag == 1'b1, tag, "toFlag after restart", int'(toFlag), 1);
  endtask

  initial begin
    #(8 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cClr, dOff, held;
    rstN = 1'b0; cfgEnable = 1'b1; swClear = 1'b0; sleepEnter = 1'b0;
    sleeping = 1'b0; preAssign = 1'b0; preRatio = 3'd0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(resetReq == 1'b0, "R1", "resetReq in reset", int'(resetReq), 0);
    check(wakeReq == 1'b0, "R1", "wakeReq in reset", int'(wakeReq), 0);
    check(toFlag == 1'b1, "R1", "toFlag in reset", int'(toFlag), 1);
    rstN = 1'b1;
    period = BASE;
    nextDue = BASE;

    // R2, R5, R10: free running, unassigned prescaler
    curTag = "R10";
    runFor(40);

    // R4: software restart mid-period
    restart("R4", 1'b0, 0, 1'b0, 1'b0);
    runFor(9);
    restart("R4", 1'b0, 0, 1'b0, 1'b0);
    runFor(20);

    // R3: prescaler ratios 1, 8, 128
    restart("R3", 1'b1, 0, 1'b0, 1'b0);
    runFor(40);
    restart("R3", 1'b1, 3, 1'b0, 1'b0);
    runFor(300);
    restart("R3", 1'b1, 7, 1'b0, 1'b0);
    runFor(2 * 2048 + 5);

    // R4: restart also zeroes the prescaler (ratio 4)
    restart("R4", 1'b1, 2, 1'b0, 1'b0);
    runFor(50);
    restart("R4", 1'b1, 2, 1'b0, 1'b0);
    runFor(70);

    // R11: restart on the completing edge wins
    restart("R11", 1'b0, 0, 1'b0, 1'b0);
    runFor(nextDue - 1 - cyc);
    restart("R11", 1'b0, 0, 1'b0, 1'b0);
    check(!resetReq && !wakeReq, "R11", "request on colliding edge", int'({resetReq, wakeReq}), 0);
    runFor(20);

    // R6, R7: sleep entry restarts, expiry only wakes
    restart("R7", 1'b1, 1, 1'b1, 1'b1);
    curTag = "R6";
    runFor(2 * 32 + 3);
    sleeping = 1'b0;
    curTag = "R5";
    runFor(40);

    // R8: disabled counters hold and stay silent
    restart("R8", 1'b0, 0, 1'b0, 1'b0);
    cClr = cyc;
    runFor(6);
    cfgEnable = 1'b0;
    dOff = cyc + 1;
    nextDue = 1 << 30;
    runFor(300);
    check(!resetReq && !wakeReq, "R8", "request while disabled", int'({resetReq, wakeReq}), 0);
    cfgEnable = 1'b1;
    held = dOff - 1 - cClr;
    nextDue = cyc + 1 + (period - held) - 1;
    runFor(40);

    check(q.size() == 0, "R10", "requests still pending", q.size(), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule